// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Clock Generator

This block turns one fast master clock into the two clock phases needed by a processor that is built around a two-phase clock. Each cycle of its sequence has four parts. First a phase-one pulse. Then a guard gap in which neither phase is high. Then a longer phase-two pulse. Then a second gap. The sequence then starts over. The two pulse widths and the two gaps are counts of master-clock cycles, set at elaboration. Together with the master period, these counts fix the real pulse times.

Every output comes straight from a flop, so no output can glitch. A registered strobe marks the first master cycle of every phase-one pulse, which lets other logic align to the two-phase frame. The reset input is asynchronous and active low. Its release is synchronised inside the block. After release, the sequence always restarts at the beginning of a phase-one pulse.

Top module: `biphase_clkgen`

## Requirements
- R1: `phi1` and `phi2` are never high in the same master cycle.
- R2: Every `phi2` pulse is preceded by a `phi1` pulse that came after the previous `phi2` pulse, so the two phases strictly alternate.
- R3: Each `phi1` pulse lasts exactly `PH1_CYC` master cycles.
- R4: Each `phi2` pulse lasts exactly `PH2_CYC` master cycles.
- R5: From the fall of `phi1` to the rise of `phi2`, both outputs stay low for exactly `GAP12_CYC` cycles. From the fall of `phi2` to the next rise of `phi1`, both stay low for exactly `GAP21_CYC` cycles.
- R6: `sync_pulse` is high for exactly one cycle: the first cycle of every `phi1` pulse. It is low at all other times.
- R7: While `rst_n` is low, all three outputs are low. After `rst_n` rises between clock edges, the outputs stay low through two rising edges. `phi1` and `sync_pulse` go high on the third rising edge.
- R8: The pattern repeats without end, with a period of `PH1_CYC+GAP12_CYC+PH2_CYC+GAP21_CYC` cycles.
- R9: Elaboration fails in any of these cases:
  - `PH1_CYC*MCLK_PS` is below 60000 ps.
  - `PH2_CYC*MCLK_PS` is below 220000 ps.
  - Either gap is below one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| phi1 | output | 1 | Phase-one clock, registered |
| phi2 | output | 1 | Phase-two clock, registered |
| sync_pulse | output | 1 | One-cycle strobe at the start of each phase-one pulse |

## Verification
The bench builds the block with a 10 ns master period. It sets `PH1_CYC=6` and `PH2_CYC=22`, so both pulses sit exactly on their minimum real widths. It sets `GAP12_CYC=1`, a single-cycle gap, which is the tightest spacing that still keeps the phases apart. It sets `GAP21_CYC=3`, so the two gaps are unequal and a swapped gap count shows up. The short 32-cycle period lets the bench cover several complete frames. It also asserts reset in the middle of a phase-one pulse and checks that the sequence restarts cleanly.

// File: rtl/biphase_pkg.sv
`timescale 1ns/1ps
package biphase_pkg;
  typedef enum logic [1:0] {
    SEG_PH1  = 2'd0,
    SEG_GAPA = 2'd1,
    SEG_PH2  = 2'd2,
    SEG_GAPB = 2'd3
  } seg_e;
endpackage

// File: rtl/biphase_rst_sync.sv
`timescale 1ns/1ps
module biphase_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/biphase_seq.sv
`timescale 1ns/1ps
module biphase_seq
  import biphase_pkg::*;
#(
  parameter int PH1_CYC   = 7,
  parameter int GAP12_CYC = 2,
  parameter int PH2_CYC   = 23,
  parameter int GAP21_CYC = 2
) (
  input  logic clk,
  input  logic rst_sync_n,
  output seg_e seg,
  output logic seg_first
);
  localparam int MAX_A  = (PH1_CYC > GAP12_CYC) ? PH1_CYC : GAP12_CYC;
  localparam int MAX_B  = (PH2_CYC > GAP21_CYC) ? PH2_CYC : GAP21_CYC;
  localparam int MAX_W  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW     = $clog2(MAX_W + 1);
  localparam logic [CW-1:0] LAST1  = CW'(PH1_CYC - 1);
  localparam logic [CW-1:0] LASTGA = CW'(GAP12_CYC - 1);
  localparam logic [CW-1:0] LAST2  = CW'(PH2_CYC - 1);
  localparam logic [CW-1:0] LASTGB = CW'(GAP21_CYC - 1);

  seg_e          seg_q, seg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = 1'b1;

  always_comb begin
    seg_d = seg_q;
    cnt_d = cnt_q + 1'b1;
    unique case (seg_q)
      SEG_PH1:  if (cnt_q == LAST1)  begin seg_d = SEG_GAPA; cnt_d = '0; end
      SEG_GAPA: if (cnt_q == LASTGA) begin seg_d = SEG_PH2;  cnt_d = '0; end
      SEG_PH2:  if (cnt_q == LAST2)  begin seg_d = SEG_GAPB; cnt_d = '0; end
      SEG_GAPB: if (cnt_q == LASTGB) begin seg_d = SEG_PH1;  cnt_d = '0; end
      default:  begin seg_d = SEG_PH1; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      seg_q <= SEG_PH1;
      cnt_q <= '0;
    end else if (cnt_en) begin
      seg_q <= seg_d;
      cnt_q <= cnt_d;
    end
  end

  assign seg       = seg_q;
  assign seg_first = (cnt_q == '0);
endmodule

// File: rtl/biphase_outreg.sv
`timescale 1ns/1ps
module biphase_outreg
  import biphase_pkg::*;
(
  input  logic clk,
  input  logic rst_sync_n,
  input  seg_e seg,
  input  logic seg_first,
  output logic phi1,
  output logic phi2,
  output logic sync_pulse
);
  logic p1_d, p2_d, sy_d;
  logic p1_q, p2_q, sy_q;

  always_comb begin
    p1_d = (seg == SEG_PH1);
    p2_d = (seg == SEG_PH2);
    sy_d = (seg == SEG_PH1) && seg_first;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      p1_q <= 1'b0;
      p2_q <= 1'b0;
      sy_q <= 1'b0;
    end else begin
      p1_q <= p1_d;
      p2_q <= p2_d;
      sy_q <= sy_d;
    end
  end

  assign phi1       = p1_q;
  assign phi2       = p2_q;
  assign sync_pulse = sy_q;
endmodule

// File: rtl/biphase_clkgen.sv
`timescale 1ns/1ps
module biphase_clkgen
  import biphase_pkg::*;
#(
  parameter int MCLK_PS   = 10000,
  parameter int PH1_CYC   = 7,
  parameter int GAP12_CYC = 2,
  parameter int PH2_CYC   = 23,
  parameter int GAP21_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic phi1,
  output logic phi2,
  output logic sync_pulse
);
  localparam int MIN_PH1_PS = 60000;
  localparam int MIN_PH2_PS = 220000;

  // R9: parameter sanity at elaboration
  if (PH1_CYC * MCLK_PS < MIN_PH1_PS) begin : g_bad_ph1
    $error("phase-one width below minimum");
  end
  if (PH2_CYC * MCLK_PS < MIN_PH2_PS) begin : g_bad_ph2
    $error("phase-two width below minimum");
  end
  if (GAP12_CYC < 1 || GAP21_CYC < 1) begin : g_bad_gap
    $error("guard gaps must be at least one cycle");
  end

  logic rst_sync_n;
  seg_e seg;
  logic seg_first;

  biphase_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  biphase_seq #(
    .PH1_CYC   (PH1_CYC),
    .GAP12_CYC (GAP12_CYC),
    .PH2_CYC   (PH2_CYC),
    .GAP21_CYC (GAP21_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .seg        (seg),
    .seg_first  (seg_first)
  );

  biphase_outreg u_out (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .seg        (seg),
    .seg_first  (seg_first),
    .phi1       (phi1),
    .phi2       (phi2),
    .sync_pulse (sync_pulse)
  );
endmodule

// File: rtl/biphase_clkgen_chk.sv
`timescale 1ns/1ps
module biphase_clkgen_chk #(
  parameter int PH1_CYC   = 7,
  parameter int GAP12_CYC = 2,
  parameter int PH2_CYC   = 23,
  parameter int GAP21_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic phi1,
  input logic phi2,
  input logic sync_pulse
);
  logic [15:0] run1_q, run2_q, low_q;
  logic [1:0]  last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run1_q <= '0;
      run2_q <= '0;
      low_q  <= '0;
      last_q <= 2'd0;
    end else begin
      run1_q <= phi1 ? run1_q + 16'd1 : 16'd0;
      run2_q <= phi2 ? run2_q + 16'd1 : 16'd0;
      low_q  <= (phi1 || phi2) ? 16'd0 : low_q + 16'd1;
      if (phi1)      last_q <= 2'd1;
      else if (phi2) last_q <= 2'd2;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi1 && phi2)); // R1

  AST_PHI2_AFTER_PHI1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi2) |-> (last_q == 2'd1)); // R2

  AST_PH1_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi1) |-> (run1_q == 16'(PH1_CYC))); // R3

  AST_PH2_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi2) |-> (run2_q == 16'(PH2_CYC))); // R4

  AST_GAP_BEFORE_PH2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi2) |-> (low_q == 16'(GAP12_CYC))); // R5

  AST_GAP_BEFORE_PH1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phi1) && last_q == 2'd2) |-> (low_q == 16'(GAP21_CYC))); // R5

  AST_SYNC_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi1) |-> sync_pulse); // R6

  AST_SYNC_ONLY_START: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> (phi1 && run1_q == 16'd0)); // R6
endmodule

bind biphase_clkgen biphase_clkgen_chk #(
  .PH1_CYC   (PH1_CYC),
  .GAP12_CYC (GAP12_CYC),
  .PH2_CYC   (PH2_CYC),
  .GAP21_CYC (GAP21_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phi1       (phi1),
  .phi2       (phi2),
  .sync_pulse (sync_pulse)
);

// File: tb/biphase_clkgen_test.sv
`timescale 1ns/1ps
module biphase_clkgen_test;
  // Bench sits exactly on the minimum real widths (R9) with a one-cycle gap.
  localparam int MCLK_PS = 10000;
  localparam int W1 = 6;
  localparam int G1 = 1;
  localparam int W2 = 22;
  localparam int G2 = 3;
  localparam int PER = W1 + G1 + W2 + G2;

  typedef struct {
    bit    p1;
    bit    p2;
    bit    sy;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic phi1, phi2, sync_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit saw_p1 = 1'b0;
  bit prev_p2 = 1'b0;
  item_t sb[$];

  always #5 clk = ~clk;

  biphase_clkgen #(
    .MCLK_PS(MCLK_PS), .PH1_CYC(W1), .GAP12_CYC(G1),
    .PH2_CYC(W2), .GAP21_CYC(G2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2), .sync_pulse(sync_pulse)
  );

  // k = rising edges since reset release; model from R3..R8
  function automatic item_t model(int k);
    item_t it;
    int pos;
    it.p1 = 0; it.p2 = 0; it.sy = 0; it.tag = "R7";
    if (k < 2) return it;
    pos = (k - 2) % PER;
    if (pos < W1) begin
      it.p1 = 1; it.sy = (pos == 0);
      it.tag = (pos == 0) ? "R6" : "R3";
    end else if (pos < W1 + G1) begin
      it.tag = "R5";
    end else if (pos < W1 + G1 + W2) begin
      it.p2 = 1; it.tag = "R4";
    end else begin
      it.tag = "R5";
    end
    if ((k - 2) >= PER && pos == 0) it.tag = "R8";
    return it;
  endfunction

  task automatic hold_reset(int n);
    item_t z;
    z.p1 = 0; z.p2 = 0; z.sy = 0; z.tag = "R7";
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      sb.push_back(z);
    end
  endtask

  task automatic run_cycles(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      sb.push_back(model(k));
    end
  endtask

  // driver
  initial begin
    rst_n = 1'b0;
    hold_reset(3);
    @(negedge clk) rst_n = 1'b1;
    run_cycles(3 * PER + 5);
    // reset in the middle of a phase-one pulse
    @(negedge clk) rst_n = 1'b0;
    hold_reset(2);
    @(negedge clk) rst_n = 1'b1;
    run_cycles(2 * PER + 3);
    @(posedge clk);
    #4;
    done = 1'b1;
  end

  // monitor / scoreboard
  always @(posedge clk) begin
    #3;
    if (sb.size() > 0) begin
      item_t e;
      e = sb.pop_front();
      checks++;
      if (phi1 !== e.p1 || phi2 !== e.p2 || sync_pulse !== e.sy) begin
        fails++;
        $display("FAIL %s: got phi1=%b phi2=%b sync=%b, expected phi1=%b phi2=%b sync=%b",
                 e.tag, phi1, phi2, sync_pulse, e.p1, e.p2, e.sy);
      end
      checks++;
      if (phi1 === 1'b1 && phi2 === 1'b1) begin
        fails++;
        $display("FAIL R1: got phi1=1 phi2=1, expected not both high");
      end
      if (!rst_n) begin
        saw_p1 = 1'b0;
      end else begin
        if (phi1 === 1'b1) saw_p1 = 1'b1;
        if (phi2 === 1'b1 && prev_p2 == 1'b0) begin
          checks++;
          if (!saw_p1) begin
            fails++;
            $display("FAIL R2: got phi2 rise without prior phi1, expected phi1 pulse first");
          end
          saw_p1 = 1'b0;
        end
      end
      prev_p2 = (phi2 === 1'b1);
    end
  end

  initial begin
    wait (done);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog: got no completion, expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule